// File: doc/BRIEF.md
# Programmable I/O pin controller

This block manages a bank of general-purpose pins (32 by default). Each pin either carries its normal peripheral function or is handed over to software as a programmable I/O. Six configuration registers select, for each pin: normal or programmable mode, input or output direction, output data, whether a weak pull is enabled, whether that pull is up or down, and push-pull or open-drain drive. From these settings and the peripheral's own drive request, the block computes four signals for every pad wrapper: drive-enable, drive-value, pull-up-enable and pull-down-enable. The live pad levels pass through a two-stage synchroniser and can be read as a pin-state register.

The reset configuration of each pin comes from parameters. A strap input, sampled while reset is held, can return a chosen group of pins to normal function. While the external bus is granted away, every chip-select pin that is a programmable input has its pull-up forced on.

The register port is plain control with no back-pressure. A write takes effect at the clock edge where `wr_en` is high and is visible on the pad outputs straight after that edge. `rd_data` follows `rd_addr` combinationally. There is no streaming data path.

Top module: `pio_bank`

## Requirements
- R1: Register addresses are 0 mode (1 = programmable), 1 direction (1 = output), 2 data, 3 pull enable, 4 pull select (1 = up, 0 = down) and 5 open-drain. A value written to any of them is read back unchanged.
- R2: A pin in normal mode (mode bit 0) drives `pad_oe` = `periph_oe` and `pad_out` = `periph_oe & periph_out`, with both pulls off.
- R3: A pin in programmable mode ignores `periph_oe` and `periph_out` completely.
- R4: A programmable output in push-pull mode drives `pad_oe` = 1 and `pad_out` = data bit, with both pulls off.
- R5: A programmable input has `pad_oe` = 0 and `pad_out` = 0. Its pull-up is on when pull enable = 1 and select = 1, its pull-down is on when pull enable = 1 and select = 0, and neither is on when pull enable = 0.
- R6: A programmable output in open-drain mode has `pad_out` = 0 and drives (`pad_oe` = 1) only when its data bit is 0.
- R7: While `rst_n` is low with `strap_ovr_n` high, each register loads its reset default. With the default parameters: mode 32'hFFFF_FFF0, direction 0, pull enable 32'hFFFF_FFF0, pull select 32'h0000_FFFF.
- R8: If `strap_ovr_n` is low in the last reset cycle, the override pins (default bits 5 and 4) reset to normal mode. Mode then reads 32'hFFFF_FFC0.
- R9: While `bus_hold_ack` is 1, a chip-select pin (default bits 23..16) that is a programmable input has its pull-up on and its pull-down off, whatever its pull settings. Outputs and normal-mode pins are not affected.
- R10: Address 6 returns `pad_in` delayed by exactly two clock edges, in every mode. Writes to address 6 have no effect.
- R11: `pad_pu` and `pad_pd` are never both 1 on the same pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_ovr_n | input | 1 | Bus-override strap, low = override, sampled during reset |
| bus_hold_ack | input | 1 | High while the external bus is granted away |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data |
| periph_oe | input | 32 | Peripheral drive request per pin |
| periph_out | input | 32 | Peripheral drive value per pin |
| pad_in | input | 32 | Raw pad levels |
| pad_oe | output | 32 | Pad drive enable |
| pad_out | output | 32 | Pad drive value |
| pad_pu | output | 32 | Pad weak pull-up enable |
| pad_pd | output | 32 | Pad weak pull-down enable |

## Verification
The assertions check four properties on every cycle. Pulls are never both on. An open-drain pin never drives high. The forced pull-up holds on chip-select inputs during a bus hold. The pin-state register equals the pad level from two edges earlier. After each reset they also check the mode register against the strap. A vector table, applied to one chip-select pin and one ordinary pin, shows the mode, direction, drive and pull combinations. Directed scenarios cover the rest: register readback, independence from the peripheral in programmable mode, both strap settings and the synchroniser's exact latency.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE   = 3'd0,
    REG_DIR    = 3'd1,
    REG_DATA   = 3'd2,
    REG_PULLEN = 3'd3,
    REG_PULLUP = 3'd4,
    REG_ODRAIN = 3'd5,
    REG_STATE  = 3'd6
  } pio_reg_e;

  // per-pin configuration as seen by one pin cell
  typedef struct packed {
    logic prog;     // 1 = programmable I/O, 0 = peripheral
    logic out_dir;  // 1 = output
    logic data;
    logic pull_en;
    logic pull_up;  // 1 = up, 0 = down
    logic odrain;
  } pin_cfg_t;
endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
  import pio_pkg::*;
#(
  parameter int unsigned    N           = 32,
  parameter logic [N-1:0]   DEF_MODE    = '1,
  parameter logic [N-1:0]   DEF_PULL_EN = '1,
  parameter logic [N-1:0]   DEF_PULL_UP = '1,
  parameter logic [N-1:0]   OVR_MASK    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_ovr_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [N-1:0]      state_in,
  output logic [N-1:0]      rd_data,
  output logic [N-1:0]      mode_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      data_q,
  output logic [N-1:0]      pen_q,
  output logic [N-1:0]      pup_q,
  output logic [N-1:0]      od_q
);
  logic [N-1:0] ovr_keep;

  // pins in OVR_MASK fall back to normal function when the strap is low
  assign ovr_keep = strap_ovr_n ? {N{1'b1}} : ~OVR_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= DEF_MODE & ovr_keep;
      dir_q  <= '0;
      data_q <= '0;
      pen_q  <= DEF_PULL_EN & ovr_keep;
      pup_q  <= DEF_PULL_UP;
      od_q   <= '0;
    end else if (wr_en) begin
      unique case (pio_reg_e'(wr_addr))
        REG_MODE:   mode_q <= wr_data;
        REG_DIR:    dir_q  <= wr_data;
        REG_DATA:   data_q <= wr_data;
        REG_PULLEN: pen_q  <= wr_data;
        REG_PULLUP: pup_q  <= wr_data;
        REG_ODRAIN: od_q   <= wr_data;
        default:    ;  // state register and unused codes are read-only
      endcase
    end
  end

  always_comb begin
    unique case (pio_reg_e'(rd_addr))
      REG_MODE:   rd_data = mode_q;
      REG_DIR:    rd_data = dir_q;
      REG_DATA:   rd_data = data_q;
      REG_PULLEN: rd_data = pen_q;
      REG_PULLUP: rd_data = pup_q;
      REG_ODRAIN: rd_data = od_q;
      REG_STATE:  rd_data = state_in;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned N      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0] stage_q [STAGES];

  // free-running chain: no reset, so the latency is the same in every cycle
  always_ff @(posedge clk) stage_q[0] <= async_in;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pio_pin_cell.sv
module pio_pin_cell
  import pio_pkg::*;
#(
  parameter bit IS_CS = 1'b0
) (
  input  pin_cfg_t cfg,
  input  logic     bus_hold,
  input  logic     periph_oe,
  input  logic     periph_out,
  output logic     oe,
  output logic     out,
  output logic     pu,
  output logic     pd
);
  always_comb begin
    oe  = 1'b0;
    out = 1'b0;
    pu  = 1'b0;
    pd  = 1'b0;
    if (!cfg.prog) begin
      oe  = periph_oe;
      out = periph_oe & periph_out;
    end else if (cfg.out_dir) begin
      if (cfg.odrain) begin
        oe = ~cfg.data;          // sink only, release on 1
      end else begin
        oe  = 1'b1;
        out = cfg.data;
      end
    end else if (IS_CS && bus_hold) begin
      pu = 1'b1;                 // forced while bus is granted away
    end else begin
      pu = cfg.pull_en & cfg.pull_up;
      pd = cfg.pull_en & ~cfg.pull_up;
    end
  end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int unsigned  N           = 32,
  parameter int unsigned  SYNC_STAGES = 2,
  parameter logic [N-1:0] DEF_MODE    = 32'hFFFF_FFF0,
  parameter logic [N-1:0] DEF_PULL_EN = 32'hFFFF_FFF0,
  parameter logic [N-1:0] DEF_PULL_UP = 32'h0000_FFFF,
  parameter logic [N-1:0] OVR_MASK    = 32'h0000_0030,
  parameter logic [N-1:0] CS_MASK     = 32'h00FF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_ovr_n,
  input  logic              bus_hold_ack,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [N-1:0]      rd_data,
  input  logic [N-1:0]      periph_oe,
  input  logic [N-1:0]      periph_out,
  input  logic [N-1:0]      pad_in,
  output logic [N-1:0]      pad_oe,
  output logic [N-1:0]      pad_out,
  output logic [N-1:0]      pad_pu,
  output logic [N-1:0]      pad_pd
);
  logic [N-1:0] mode_q, dir_q, data_q, pen_q, pup_q, od_q;
  logic [N-1:0] state_q;

  pio_cfg_regs #(
    .N(N), .DEF_MODE(DEF_MODE), .DEF_PULL_EN(DEF_PULL_EN),
    .DEF_PULL_UP(DEF_PULL_UP), .OVR_MASK(OVR_MASK)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .strap_ovr_n(strap_ovr_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .state_in(state_q), .rd_data(rd_data),
    .mode_q(mode_q), .dir_q(dir_q), .data_q(data_q),
    .pen_q(pen_q), .pup_q(pup_q), .od_q(od_q)
  );

  pio_sync #(.N(N), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .async_in(pad_in), .sync_out(state_q)
  );

  for (genvar p = 0; p < N; p++) begin : g_pin
    pin_cfg_t cfg;
    assign cfg = '{prog: mode_q[p], out_dir: dir_q[p], data: data_q[p],
                   pull_en: pen_q[p], pull_up: pup_q[p], odrain: od_q[p]};

    pio_pin_cell #(.IS_CS(CS_MASK[p])) cell_i (
      .cfg(cfg), .bus_hold(bus_hold_ack),
      .periph_oe(periph_oe[p]), .periph_out(periph_out[p]),
      .oe(pad_oe[p]), .out(pad_out[p]), .pu(pad_pu[p]), .pd(pad_pd[p])
    );
  end
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
  parameter int unsigned  N        = 32,
  parameter logic [N-1:0] DEF_MODE = '1,
  parameter logic [N-1:0] OVR_MASK = '0,
  parameter logic [N-1:0] CS_MASK  = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         strap_ovr_n,
  input logic         bus_hold_ack,
  input logic [N-1:0] pad_in,
  input logic [N-1:0] pad_oe,
  input logic [N-1:0] pad_out,
  input logic [N-1:0] pad_pu,
  input logic [N-1:0] pad_pd,
  input logic [N-1:0] mode_q,
  input logic [N-1:0] dir_q,
  input logic [N-1:0] od_q,
  input logic [N-1:0] state_q
);
  // R11
  pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  // R6
  odrain_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & dir_q & od_q & pad_oe & pad_out) == '0);

  // R9
  hold_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hold_ack |-> ((CS_MASK & mode_q & ~dir_q & ~pad_pu) == '0));

  // R10
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == $past(pad_in, 2));

  // R7 R8
  reset_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |->
      mode_q == (DEF_MODE & ($past(strap_ovr_n) ? {N{1'b1}} : ~OVR_MASK)));
endmodule

bind pio_bank pio_bank_chk #(
  .N(N), .DEF_MODE(DEF_MODE), .OVR_MASK(OVR_MASK), .CS_MASK(CS_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .strap_ovr_n(strap_ovr_n),
  .bus_hold_ack(bus_hold_ack), .pad_in(pad_in), .pad_oe(pad_oe),
  .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
  .mode_q(mode_q), .dir_q(dir_q), .od_q(od_q), .state_q(state_q)
);

// File: tb/pio_bank_tb_top.sv
module pio_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_ovr_n = 1'b1;
  logic        bus_hold_ack = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] periph_oe = '0, periph_out = '0, pad_in = '0;
  logic [31:0] pad_oe, pad_out, pad_pu, pad_pd;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  pio_bank dut_i (
    .clk(clk), .rst_n(rst_n), .strap_ovr_n(strap_ovr_n),
    .bus_hold_ack(bus_hold_ack), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .periph_oe(periph_oe), .periph_out(periph_out), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic do_reset(logic strap);
    @(negedge clk);
    rst_n = 1'b0; strap_ovr_n = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; strap_ovr_n = 1'b1;
    #1;
  endtask

  // [11] cs pin [10] mode [9] dir [8] data [7] pull_en [6] pull_up
  // [5] odrain [4] hold | [3] oe [2] out [1] pu [0] pd
  localparam logic [11:0] VEC [15] = '{
    12'b0000_0000_1100,  // R2 normal
    12'b0111_0000_1100,  // R4 push-pull 1
    12'b0110_0000_1000,  // R4 push-pull 0
    12'b0110_0010_1000,  // R6 od low
    12'b0111_0010_0000,  // R6 od release
    12'b0101_1100_0010,  // R5 pull-up
    12'b0100_1000_0001,  // R5 pull-down
    12'b0100_0000_0000,  // R5 no pull
    12'b0100_0001_0000,  // R9 non-cs pin in hold
    12'b1100_0001_0010,  // R9 forced up
    12'b1100_1001_0010,  // R9 forced over pull-down
    12'b1111_0001_1100,  // R9 output unaffected
    12'b1000_0001_1100,  // R9 normal unaffected
    12'b1100_1000_0001,  // R9 no hold
    12'b0111_1100_1100   // R4 pulls off on output
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R7 reset defaults, strap high
    rd(3'd0, v); check("R7 mode default", v, 32'hFFFF_FFF0);
    rd(3'd1, v); check("R7 dir default", v, 32'h0);
    rd(3'd3, v); check("R7 pull_en default", v, 32'hFFFF_FFF0);
    check("R7 pad_pu after reset", pad_pu, 32'h0000_FFF0);
    check("R7 pad_pd after reset", pad_pd, 32'hFFFF_0000);

    // R1 register readback
    for (int a = 0; a < 6; a++) begin
      wr(3'(a), 32'h1357_9BDF ^ (32'h0101_0101 << a));
      rd(3'(a), v);
      check("R1 readback", v, 32'h1357_9BDF ^ (32'h0101_0101 << a));
    end

    // vector table
    periph_oe = '1; periph_out = '1;
    for (int i = 0; i < 15; i++) begin
      int pin;
      logic [11:0] t;
      t = VEC[i];
      pin = t[11] ? 20 : 8;
      bus_hold_ack = 1'b0;
      wr(3'd0, {31'b0, t[10]} << pin);
      wr(3'd1, {31'b0, t[9]}  << pin);
      wr(3'd2, {31'b0, t[8]}  << pin);
      wr(3'd3, {31'b0, t[7]}  << pin);
      wr(3'd4, {31'b0, t[6]}  << pin);
      wr(3'd5, {31'b0, t[5]}  << pin);
      bus_hold_ack = t[4];
      #1;
      check($sformatf("vector %0d (R2 R4 R5 R6 R9)", i),
            {28'b0, pad_oe[pin], pad_out[pin], pad_pu[pin], pad_pd[pin]},
            {28'b0, t[3:0]});
      check($sformatf("R11 vector %0d", i), pad_pu & pad_pd, 32'h0);
    end
    bus_hold_ack = 1'b0;

    // R3 peripheral ignored in programmable mode (pin 8 input, no pull)
    wr(3'd0, 32'h0000_0100); wr(3'd1, 32'h0); wr(3'd3, 32'h0);
    periph_oe = '1; periph_out = '1; #1;
    check("R3 periph high", {30'b0, pad_oe[8], pad_out[8]}, 32'h0);
    periph_oe = '0; periph_out = '0; #1;
    check("R3 periph low", {30'b0, pad_oe[8], pad_out[8]}, 32'h0);

    // R10 synchroniser latency and read-only state
    @(negedge clk); pad_in = 32'hA5A5_5A5A;
    @(negedge clk); pad_in = 32'h0F0F_F0F0;
    rd(3'd6, v); check("R10 after one edge", v, 32'h0);
    @(negedge clk);
    rd(3'd6, v); check("R10 after two edges", v, 32'hA5A5_5A5A);
    @(negedge clk);
    rd(3'd6, v); check("R10 second value", v, 32'h0F0F_F0F0);
    wr(3'd6, 32'h1234_5678);
    rd(3'd6, v); check("R10 write ignored", v, 32'h0F0F_F0F0);
    rd(3'd0, v); check("R10 write leaves mode", v, 32'h0000_0100);

    // R8 override strap low
    do_reset(1'b0);
    rd(3'd0, v); check("R8 mode with override", v, 32'hFFFF_FFC0);
    check("R8 pad_pu with override", pad_pu, 32'h0000_FFC0);
    do_reset(1'b1);
    rd(3'd0, v); check("R7 mode after second reset", v, 32'hFFFF_FFF0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule